// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

A ten-state counter held in five flip-flops wired as a twisted ring. Each ring pattern is decoded to one of ten active-high one-hot outputs. An active-low carry output goes low for the upper half of the count, so one stage can clock the next. Two advance inputs of opposite polarity step the count. Each one is qualified by the level of the other: a rising edge on the first while the second is low, or a falling edge on the second while the first is high.

The block runs from a free-running system clock. Both advance inputs pass through a synchronizer, and their edges are found by comparing successive samples. A high level on the clear input forces count 0 at once, with no clock needed. Edges that arrive while clear is high are dropped. Any ring pattern outside the ten legal ones is put back into the cycle on the next advance. An active-low system reset also puts the block in count 0.

Top module: `decade_ring_counter`

## Requirements
- R1: While `clear_i` is high or `rst_ni` is low, the outputs show count 0 (`dec_o` = 10'b00_0000_0001, `carry_no` = 1) at once, whatever the clock and advance inputs do.
- R2: In every legal state exactly one bit of `dec_o` is high. Bit k is high for count k, and the ring pattern for count k (bit 0 first) is the sequence 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 read as bits 4..0.
- R3: A low-to-high change on `adv_rise_i` while `adv_fall_i` is low advances the count by one.
- R4: A high-to-low change on `adv_fall_i` while `adv_rise_i` is high advances the count by one.
- R5: No other change of the advance inputs advances the count. This covers a fall of `adv_rise_i`, a rise of `adv_fall_i`, a rise of `adv_rise_i` while `adv_fall_i` is high, a fall of `adv_fall_i` while `adv_rise_i` is low, and both inputs rising together.
- R6: `carry_no` is low for counts 5 to 9 and high for counts 0 to 4.
- R7: Advancing from count 9 gives count 0.
- R8: Advance edges that occur while `clear_i` is high are discarded. An input that is already high when clear falls does not advance the count. The first qualifying edge after clear is released advances it.
- R9: From any illegal ring pattern, the next advance loads count 0, well inside the limit of 11 advances.
- R10: Each advance from a legal state changes exactly one ring bit, so exactly two bits of `dec_o` change.
- R11: An input change made between clock edges shows on the outputs after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| clear_i | input | 1 | Asynchronous clear to count 0, active high |
| adv_rise_i | input | 1 | Advance on rising edge, qualified by `adv_fall_i` low |
| adv_fall_i | input | 1 | Advance on falling edge, qualified by `adv_rise_i` high |
| dec_o | output | 10 | One-hot decoded count, bit k for count k |
| carry_no | output | 1 | Low for counts 5 to 9 |

## Verification
A vector table drives every ordered pair of advance-input changes, including the four non-qualifying ones and a change on both inputs at once. A design that ignored the qualifying level, or that treated the falling input as rising, would step on those vectors. Directed tests hold an advance input high across the release of clear. A detector reset by clear, rather than tracking through it, would count a false edge there. Illegal ring patterns are forced into the state register to show that a design lacking correction stays outside the cycle. A latency probe catches an added or missing pipeline stage.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    ADV_NONE = 2'b00,
    ADV_RISE = 2'b01,
    ADV_FALL = 2'b10,
    ADV_BOTH = 2'b11
  } adv_src_e;
endpackage

// File: rtl/drc_sync.sv
module drc_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/drc_edge_qual.sv
module drc_edge_qual
  import drc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rise_s_i,
  input  logic     fall_s_i,
  output adv_src_e src_o,
  output logic     adv_o
);
  logic rise_prev_q, fall_prev_q;
  logic rise_hit, fall_hit;

  // previous samples track through clear so held levels are not seen as edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_prev_q <= 1'b0;
      fall_prev_q <= 1'b0;
    end else begin
      rise_prev_q <= rise_s_i;
      fall_prev_q <= fall_s_i;
    end
  end

  assign rise_hit = rise_s_i & ~rise_prev_q & ~fall_s_i;
  assign fall_hit = ~fall_s_i & fall_prev_q & rise_s_i;
  assign src_o    = adv_src_e'({fall_hit, rise_hit});
  assign adv_o    = (src_o != ADV_NONE);
endmodule

// File: rtl/drc_core.sv
module drc_core #(
  parameter int unsigned STAGES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [STAGES-1:0] state_o
);
  logic [STAGES-1:0] state_q, state_d;

  function automatic logic ring_ok(input logic [STAGES-1:0] s);
    logic [STAGES-1:0] therm;
    logic ok;
    ok = 1'b0;
    for (int k = 0; k <= STAGES; k++) begin
      therm = ~({STAGES{1'b1}} << k);
      if (s == therm || s == ~therm) ok = 1'b1;
    end
    return ok;
  endfunction

  // illegal patterns collapse to count 0 on the next advance
  always_comb begin
    state_d = state_q;
    if (adv_i) begin
      if (ring_ok(state_q)) state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
      else                  state_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni || clear_i) state_q <= '0;
    else                    state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/drc_decode.sv
module drc_decode #(
  parameter  int unsigned STAGES = 5,
  localparam int unsigned COUNT  = 2 * STAGES
) (
  input  logic [STAGES-1:0] state_i,
  output logic [COUNT-1:0]  dec_o,
  output logic              carry_no
);
  // each output looks at two adjacent ring bits only
  for (genvar k = 0; k < COUNT; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec_o[k] = ~state_i[STAGES-1] & ~state_i[0];
    end else if (k < STAGES) begin : g_low
      assign dec_o[k] = state_i[k-1] & ~state_i[k];
    end else if (k == STAGES) begin : g_full
      assign dec_o[k] = state_i[STAGES-1] & state_i[0];
    end else begin : g_high
      assign dec_o[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
    end
  end

  assign carry_no = ~state_i[STAGES-1];
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter #(
  parameter  int unsigned STAGES     = 5,
  parameter  int unsigned SYNC_DEPTH = 2,
  localparam int unsigned COUNT      = 2 * STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_rise_i,
  input  logic             adv_fall_i,
  output logic [COUNT-1:0] dec_o,
  output logic             carry_no
);
  import drc_pkg::*;

  logic [1:0]        adv_s;
  adv_src_e          adv_src;
  logic              adv_w;
  logic [STAGES-1:0] state_w;

  drc_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({adv_fall_i, adv_rise_i}),
    .q_o    (adv_s)
  );

  drc_edge_qual u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_s_i (adv_s[0]),
    .fall_s_i (adv_s[1]),
    .src_o    (adv_src),
    .adv_o    (adv_w)
  );

  drc_core #(.STAGES(STAGES)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .adv_i   (adv_w),
    .state_o (state_w)
  );

  drc_decode #(.STAGES(STAGES)) u_dec (
    .state_i  (state_w),
    .dec_o    (dec_o),
    .carry_no (carry_no)
  );

  logic unused_src;
  assign unused_src = ^adv_src;
endmodule

// File: rtl/decade_ring_counter_chk.sv
module decade_ring_counter_chk #(
  parameter  int unsigned STAGES = 5,
  localparam int unsigned COUNT  = 2 * STAGES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              adv_i,
  input logic [STAGES-1:0] state_i,
  input logic [COUNT-1:0]  dec_i,
  input logic              carry_ni
);
  logic legal;
  // a legal ring has at most one internal boundary
  assign legal = ($countones(state_i[STAGES-2:0] ^ state_i[STAGES-1:1]) <= 1);

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (dec_i == COUNT'(1) && carry_ni));

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |-> ($countones(dec_i) == 1));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (adv_i && legal) |=> (dec_i == {$past(dec_i[COUNT-2:0]), $past(dec_i[COUNT-1])}));

  p_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |-> (carry_ni == !(|dec_i[COUNT-1:STAGES])));

  p_fix_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (adv_i && !legal) |=> (dec_i == COUNT'(1)));

  p_one_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (adv_i && legal) |=> ($countones(state_i ^ $past(state_i)) == 1));
endmodule

bind decade_ring_counter decade_ring_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .adv_i    (adv_w),
  .state_i  (state_w),
  .dec_i    (dec_o),
  .carry_ni (carry_no)
);

// File: tb/decade_ring_counter_tb_top.sv
module decade_ring_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;
  // {adv_rise, adv_fall, expected count}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b10_0001, 6'b00_0001, 6'b10_0010, 6'b11_0010, 6'b10_0011,
    6'b11_0011, 6'b01_0011, 6'b11_0011, 6'b10_0100, 6'b00_0100,
    6'b01_0100, 6'b00_0100, 6'b10_0101, 6'b00_0101, 6'b10_0110,
    6'b00_0110, 6'b10_0111, 6'b00_0111, 6'b10_1000, 6'b00_1000,
    6'b10_1001, 6'b11_1001, 6'b10_0000, 6'b00_0000, 6'b11_0000,
    6'b00_0000
  };

  logic clk = 1'b0;
  logic rst_n, clear, a_rise, a_fall;
  logic [9:0] dec;
  logic carry_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decade_ring_counter dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .clear_i    (clear),
    .adv_rise_i (a_rise),
    .adv_fall_i (a_fall),
    .dec_o      (dec),
    .carry_no   (carry_n)
  );

  task automatic check_count(input string req, input int exp);
    logic [9:0] exp_dec;
    logic exp_carry;
    exp_dec = 10'(1) << exp;
    exp_carry = (exp < 5);
    checks++;
    if (dec !== exp_dec) begin
      failures++;
      $display("FAIL %s dec_o actual=%b expected=%b", req, dec, exp_dec);
    end
    checks++;
    if (carry_n !== exp_carry) begin
      failures++;
      $display("FAIL R6 (%s) carry_no actual=%b expected=%b", req, carry_n, exp_carry);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise();
    a_rise = 1'b1; wait_neg(4);
    a_rise = 1'b0; wait_neg(4);
  endtask

  task automatic inject(input logic [4:0] pat);
    @(negedge clk);
    force dut_i.u_core.state_q = pat;
    #1;
    release dut_i.u_core.state_q;
    wait_neg(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] prev_dec;
    int prev_cnt;
    logic prev_fall;
    rst_n = 1'b0; clear = 1'b0; a_rise = 1'b0; a_fall = 1'b0;
    wait_neg(3);
    check_count("R1 in reset", 0);
    rst_n = 1'b1;
    wait_neg(2);
    check_count("R1 after reset", 0);

    // R11 latency: unchanged after two edges, updated after the third
    a_rise = 1'b1;
    wait_neg(2);
    check_count("R11 two edges", 0);
    wait_neg(1);
    check_count("R11 three edges", 1);
    a_rise = 1'b0;
    wait_neg(4);

    // R1 asynchronous clear between edges
    #2 clear = 1'b1;
    #1 check_count("R1 async clear", 0);
    @(negedge clk);
    clear = 1'b0;
    wait_neg(4);

    prev_dec = dec; prev_cnt = 0; prev_fall = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      a_rise = VEC[i][5];
      a_fall = VEC[i][4];
      wait_neg(4);
      if (int'(VEC[i][3:0]) == prev_cnt)    tag = "R5";
      else if (VEC[i][3:0] == 4'd0)         tag = "R7";
      else if (prev_fall && !VEC[i][4])     tag = "R4";
      else                                  tag = "R3";
      check_count($sformatf("%s R2 vec %0d", tag, i), int'(VEC[i][3:0]));
      if (int'(VEC[i][3:0]) != prev_cnt) begin
        checks++;
        if ($countones(dec ^ prev_dec) != 2) begin
          failures++;
          $display("FAIL R10 vec %0d changed bits actual=%0d expected=2", i,
                   $countones(dec ^ prev_dec));
        end
      end
      prev_dec = dec; prev_cnt = int'(VEC[i][3:0]); prev_fall = VEC[i][4];
    end

    // R8 edges during clear are dropped
    pulse_rise(); pulse_rise(); pulse_rise();
    check_count("R3 pre-clear", 3);
    clear = 1'b1;
    #1 check_count("R1 clear mid count", 0);
    pulse_rise(); pulse_rise();
    check_count("R8 edges in clear", 0);
    a_rise = 1'b1; wait_neg(4);
    clear = 1'b0; wait_neg(4);
    check_count("R8 held level at release", 0);
    a_rise = 1'b0; wait_neg(4);
    a_rise = 1'b1; wait_neg(4);
    check_count("R8 first edge after release", 1);
    a_rise = 1'b0; wait_neg(4);

    // R9 illegal patterns recover on next advance
    inject(5'b01010);
    pulse_rise();
    check_count("R9 from 01010", 0);
    pulse_rise();
    check_count("R9 counting resumes", 1);
    inject(5'b10110);
    a_rise = 1'b1; wait_neg(4);
    a_fall = 1'b0;
    check_count("R9 from 10110", 0);
    a_rise = 1'b0; wait_neg(4);

    // R1 system reset mid count
    pulse_rise(); pulse_rise();
    check_count("R3 pre-reset", 2);
    rst_n = 1'b0;
    #1 check_count("R1 system reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_neg(3);
    check_count("R1 after second reset", 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule